// File: doc/BRIEF.md
# Triplicated Word Voter with Active-Source Reselection

This block accepts three copies of one multi-bit data word, each arriving on its own group of input pins from a single origin. It compares the copies as whole words and produces one result word together with a valid flag. When at least two copies are equal, that word is forwarded and marked valid. When all three differ, the result is invalidated and an error flag is raised instead of forcing a value. A fault that corrupts one input path, whether permanent, transient or intermittent, is therefore masked.

Beside the data path, the block keeps track of which of three redundant sources currently acts as the active manager. A per-source dissent vector reports which single copy disagreed in the current cycle. When the active source is the lone dissenter, the select output moves to one of the two agreeing sources. A saturating counter records how many cycles ended in total disagreement, and a synchronous clear input empties it.

Top module: `word_vote_reselect`

## Requirements
- R1: After reset the outputs read: vote_word 0, vote_valid 1, vote_err 0, dissent 000, active_sel 0, err_count 0.
- R2: The three inputs are registered once. If at least two of the registered words are equal, vote_word carries that word and vote_valid is 1, one clock after the inputs were applied.
- R3: If no two registered words are equal, vote_valid is 0, vote_err is 1 and vote_word is forced to 0, one clock after the inputs were applied.
- R4: dissent bit 0 belongs to in_a, bit 1 to in_b and bit 2 to in_c. A bit is 1 only when the other two copies agree and its own copy differs; with all three equal or all three different, dissent is 000.
- R5: active_sel encodes the active source as 0 (in_a), 1 (in_b) or 2 (in_c). When the active source is the lone dissenter, on the next clock active_sel takes the lowest-numbered agreeing source.
- R6: When the lone dissenter is not the active source, or there is no lone dissenter, active_sel keeps its value.
- R7: err_count increases by one on each clock that follows a cycle with vote_err at 1, and it holds at its all-ones maximum instead of wrapping.
- R8: err_clr is synchronous and takes priority over counting: on the clock where it is 1, err_count becomes 0 even if vote_err is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_a | input | WORD_W | Data copy from source 0 |
| in_b | input | WORD_W | Data copy from source 1 |
| in_c | input | WORD_W | Data copy from source 2 |
| err_clr | input | 1 | Synchronous clear of the error counter |
| vote_word | output | WORD_W | Majority word, 0 when invalid |
| vote_valid | output | 1 | At least two copies agree |
| vote_err | output | 1 | All three copies differ |
| dissent | output | 3 | Which copy is the lone dissenter |
| active_sel | output | 2 | Index of the active source |
| err_count | output | CNT_W | Saturating count of error cycles |

## Verification
The assertions check on every cycle that the forwarded word matches an agreeing pair of registered copies, that total disagreement invalidates and zeroes the output, that the dissent vector is at most one-hot and empty on error, that the select moves exactly when the active copy dissents and stays otherwise, and that the counter steps, saturates and clears. Only the bench's scenarios show the one-cycle latency measured from the pins, the specific destination of each reselection over a sequence of faults, and the counter reaching its ceiling after a long run of errors.

// File: rtl/wv_pkg.sv
package wv_pkg;

  typedef struct packed {
    logic       valid;
    logic       err;
    logic [2:0] dissent;
    logic [1:0] pick;
  } vote_info_t;

  // Classify agreement from the three pairwise equality bits.
  function automatic vote_info_t classify(input logic eq_ab, input logic eq_ac,
                                          input logic eq_bc);
    vote_info_t r;
    r.valid      = eq_ab | eq_ac | eq_bc;
    r.err        = ~r.valid;
    r.dissent[0] = eq_bc & ~eq_ab;
    r.dissent[1] = eq_ac & ~eq_ab;
    r.dissent[2] = eq_ab & ~eq_ac;
    if (eq_ab || eq_ac)  r.pick = 2'd0;
    else if (eq_bc)      r.pick = 2'd1;
    else                 r.pick = 2'd0;
    return r;
  endfunction

  // Lowest-numbered source whose dissent bit is clear.
  function automatic logic [1:0] lowest_agree(input logic [2:0] d);
    logic [1:0] r;
    r = 2'd0;
    for (int i = 2; i >= 0; i--) begin
      if (!d[i]) r = 2'(i);
    end
    return r;
  endfunction

  // Dissent bit of a given source index; index 3 never dissents.
  function automatic logic dissent_of(input logic [2:0] d, input logic [1:0] s);
    logic r;
    case (s)
      2'd0:    r = d[0];
      2'd1:    r = d[1];
      2'd2:    r = d[2];
      default: r = 1'b0;
    endcase
    return r;
  endfunction

  // Saturating increment.
  function automatic logic [31:0] sat_inc(input logic [31:0] v, input logic [31:0] max);
    return (v >= max) ? max : v + 32'd1;
  endfunction

endpackage

// File: rtl/wv_capture.sv
module wv_capture #(
  parameter int WORD_W = 16,
  parameter int COPIES = 3
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [COPIES-1:0][WORD_W-1:0] raw,
  output logic [COPIES-1:0][WORD_W-1:0] cap
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cap <= '0;
    else        cap <= raw;
  end
endmodule

// File: rtl/wv_compare.sv
module wv_compare
  import wv_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic [2:0][WORD_W-1:0] cap,
  output logic [WORD_W-1:0]      word,
  output logic                   valid,
  output logic                   err,
  output logic [2:0]             dissent
);
  localparam int NPAIR = 3;
  logic [NPAIR-1:0] eq;   // eq[0]=a/b, eq[1]=a/c, eq[2]=b/c
  vote_info_t info;

  for (genvar p = 0; p < NPAIR; p++) begin : g_pair
    localparam int LO = (p == 2) ? 1 : 0;
    localparam int HI = (p == 0) ? 1 : 2;
    assign eq[p] = (cap[LO] == cap[HI]);
  end

  always_comb begin
    info    = classify(eq[0], eq[1], eq[2]);
    valid   = info.valid;
    err     = info.err;
    dissent = info.dissent;
    word    = info.valid ? cap[info.pick] : '0;
  end
endmodule

// File: rtl/wv_select.sv
module wv_select
  import wv_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] dissent,
  output logic [1:0] sel
);
  logic       move;
  logic [1:0] target;

  always_comb begin
    move   = dissent_of(dissent, sel);
    target = lowest_agree(dissent);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    sel <= 2'd0;
    else if (move) sel <= target;
  end
endmodule

// File: rtl/wv_err_count.sv
module wv_err_count
  import wv_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             err,
  output logic [CNT_W-1:0] count
);
  localparam logic [31:0] MAXV = (CNT_W >= 32) ? 32'hFFFF_FFFF : ((32'd1 << CNT_W) - 32'd1);
  logic [31:0] nxt;

  always_comb nxt = sat_inc(32'(count), MAXV);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   count <= '0;
    else if (clr) count <= '0;
    else if (err) count <= nxt[CNT_W-1:0];
  end
endmodule

// File: rtl/word_vote_reselect.sv
module word_vote_reselect #(
  parameter int WORD_W = 16,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] in_a,
  input  logic [WORD_W-1:0] in_b,
  input  logic [WORD_W-1:0] in_c,
  input  logic              err_clr,
  output logic [WORD_W-1:0] vote_word,
  output logic              vote_valid,
  output logic              vote_err,
  output logic [2:0]        dissent,
  output logic [1:0]        active_sel,
  output logic [CNT_W-1:0]  err_count
);
  localparam int COPIES = 3;

  logic [COPIES-1:0][WORD_W-1:0] raw;
  logic [COPIES-1:0][WORD_W-1:0] cap;
  logic [WORD_W-1:0]             cap_a, cap_b, cap_c;

  assign raw   = {in_c, in_b, in_a};
  assign cap_a = cap[0];
  assign cap_b = cap[1];
  assign cap_c = cap[2];

  wv_capture #(.WORD_W(WORD_W), .COPIES(COPIES)) u_cap (
    .clk(clk), .rst_n(rst_n), .raw(raw), .cap(cap)
  );

  wv_compare #(.WORD_W(WORD_W)) u_cmp (
    .cap(cap), .word(vote_word), .valid(vote_valid),
    .err(vote_err), .dissent(dissent)
  );

  wv_select u_sel (
    .clk(clk), .rst_n(rst_n), .dissent(dissent), .sel(active_sel)
  );

  wv_err_count #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clr(err_clr), .err(vote_err), .count(err_count)
  );
endmodule

// File: rtl/wv_checker.sv
module wv_checker #(
  parameter int WORD_W = 16,
  parameter int CNT_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [WORD_W-1:0] cap_a,
  input logic [WORD_W-1:0] cap_b,
  input logic [WORD_W-1:0] cap_c,
  input logic              err_clr,
  input logic [WORD_W-1:0] vote_word,
  input logic              vote_valid,
  input logic              vote_err,
  input logic [2:0]        dissent,
  input logic [1:0]        active_sel,
  input logic [CNT_W-1:0]  err_count
);
  localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

  a_r2_pass_a: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_a == cap_b || cap_a == cap_c) |-> (vote_valid && vote_word == cap_a));

  a_r2_pass_b: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_b == cap_c) |-> (vote_valid && vote_word == cap_b));

  a_r3_total_miss: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_a != cap_b && cap_a != cap_c && cap_b != cap_c)
      |-> (vote_err && !vote_valid && vote_word == '0));

  a_r4_single_dissent: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(dissent) && !(vote_err && (dissent != 3'b000)));

  a_r5_move: assert property (@(posedge clk) disable iff (!rst_n)
    dissent[active_sel] |=> (active_sel != $past(active_sel)));

  a_r5_range: assert property (@(posedge clk) disable iff (!rst_n)
    active_sel != 2'd3);

  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !dissent[active_sel] |=> $stable(active_sel));

  a_r7_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!err_clr && vote_err && err_count != CMAX) |=> (err_count == $past(err_count) + 1'b1));

  a_r7_saturate: assert property (@(posedge clk) disable iff (!rst_n)
    (!err_clr && err_count == CMAX) |=> (err_count == CMAX));

  a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
    err_clr |=> (err_count == '0));
endmodule

bind word_vote_reselect wv_checker #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cap_a(cap_a), .cap_b(cap_b), .cap_c(cap_c),
  .err_clr(err_clr), .vote_word(vote_word), .vote_valid(vote_valid),
  .vote_err(vote_err), .dissent(dissent), .active_sel(active_sel),
  .err_count(err_count)
);

// File: tb/tb_word_vote_reselect.sv
module tb_word_vote_reselect;
  localparam int WORD_W = 16;
  localparam int CNT_W  = 8;
  localparam int NV     = 9;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [WORD_W-1:0] in_a = '0, in_b = '0, in_c = '0;
  logic              err_clr = 1'b0;
  logic [WORD_W-1:0] vote_word;
  logic              vote_valid, vote_err;
  logic [2:0]        dissent;
  logic [1:0]        active_sel;
  logic [CNT_W-1:0]  err_count;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  word_vote_reselect #(.WORD_W(WORD_W), .CNT_W(CNT_W)) dut (
    .clk(clk), .rst_n(rst_n), .in_a(in_a), .in_b(in_b), .in_c(in_c),
    .err_clr(err_clr), .vote_word(vote_word), .vote_valid(vote_valid),
    .vote_err(vote_err), .dissent(dissent), .active_sel(active_sel),
    .err_count(err_count)
  );

  // a, b, c, expected word, valid, err, dissent, select after
  localparam logic [15:0] VA [NV] = '{16'h1111, 16'h00AA, 16'h1234, 16'hDEAD, 16'h0001,
                                      16'h0003, 16'h0000, 16'hAAAA, 16'h5555};
  localparam logic [15:0] VB [NV] = '{16'h1111, 16'h00AA, 16'h5678, 16'hBEEF, 16'h0002,
                                      16'h0004, 16'h0000, 16'hBBBB, 16'h6666};
  localparam logic [15:0] VC [NV] = '{16'h1111, 16'h0055, 16'h1234, 16'hBEEF, 16'h0002,
                                      16'h0003, 16'hFFFF, 16'hCCCC, 16'h5555};
  localparam logic [15:0] EW [NV] = '{16'h1111, 16'h00AA, 16'h1234, 16'hBEEF, 16'h0002,
                                      16'h0003, 16'h0000, 16'h0000, 16'h5555};
  localparam logic        EV [NV] = '{1, 1, 1, 1, 1, 1, 1, 0, 1};
  localparam logic [2:0]  ED [NV] = '{3'b000, 3'b100, 3'b010, 3'b001, 3'b001,
                                      3'b010, 3'b100, 3'b000, 3'b010};
  localparam logic [1:0]  ES [NV] = '{2'd0, 2'd0, 2'd0, 2'd1, 2'd1, 2'd0, 2'd0, 2'd0, 2'd0};

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [15:0] a, input logic [15:0] b, input logic [15:0] c);
    in_a = a; in_b = b; in_c = c;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 word",    32'(vote_word), 32'h0);
    chk("R1 valid",   32'(vote_valid), 32'h1);
    chk("R1 err",     32'(vote_err), 32'h0);
    chk("R1 dissent", 32'(dissent), 32'h0);
    chk("R1 sel",     32'(active_sel), 32'h0);
    chk("R1 count",   32'(err_count), 32'h0);

    // Vector table: R2, R3, R4 at one clock, R5/R6 a clock later
    for (int i = 0; i < NV; i++) begin
      drive(VA[i], VB[i], VC[i]);
      @(negedge clk);
      chk($sformatf("R2/R3 word v%0d", i),  32'(vote_word), 32'(EW[i]));
      chk($sformatf("R2/R3 valid v%0d", i), 32'(vote_valid), 32'(EV[i]));
      chk($sformatf("R3 err v%0d", i),      32'(vote_err), 32'(!EV[i]));
      chk($sformatf("R4 dissent v%0d", i),  32'(dissent), 32'(ED[i]));
      @(negedge clk);
      chk($sformatf("R5/R6 sel v%0d", i),   32'(active_sel), 32'(ES[i]));
    end

    // Latency: new inputs are not visible before the capturing edge (R2)
    drive(16'h0F0F, 16'h0F0F, 16'h0F0F);
    @(posedge clk);
    #1 drive(16'hA5A5, 16'hA5A5, 16'hA5A5);
    chk("R2 latency old", 32'(vote_word), 32'h0F0F);
    @(negedge clk);
    chk("R2 latency hold", 32'(vote_word), 32'h0F0F);
    @(negedge clk);
    chk("R2 latency new", 32'(vote_word), 32'hA5A5);

    // Counter: clear, then three error cycles (R7, R8)
    err_clr = 1'b1;
    @(negedge clk);
    err_clr = 1'b0;
    chk("R8 clear", 32'(err_count), 32'h0);
    drive(16'h0001, 16'h0002, 16'h0003);
    repeat (3) @(negedge clk);
    drive(16'h0009, 16'h0009, 16'h0009);
    @(negedge clk);
    chk("R7 three errors", 32'(err_count), 32'd3);
    @(negedge clk);
    chk("R7 no error no count", 32'(err_count), 32'd3);

    // Saturation (R7)
    drive(16'h0001, 16'h0002, 16'h0003);
    repeat (300) @(negedge clk);
    chk("R7 saturate", 32'(err_count), 32'd255);
    chk("R3 long err", 32'(vote_err), 32'h1);

    // Clear wins over a live error (R8)
    err_clr = 1'b1;
    @(negedge clk);
    err_clr = 1'b0;
    chk("R8 clear priority", 32'(err_count), 32'h0);
    @(negedge clk);
    chk("R7 resume count", 32'(err_count), 32'h1);

    // Selection unaffected by total disagreement (R6)
    chk("R6 sel on error", 32'(active_sel), 32'h0);

    done = 1;
    finish_run();
  end
endmodule